// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block moves one serial word between a controller and an SPI device. The controller first selects the device with a select command. That command also captures the configuration for the whole selection: clock polarity and phase, bit order, shared data line use, loopback and the clock divider. Each start strobe then shifts one word of 1 to `MAX_W` bits out on the data output while it samples a word back in. The engine generates the serial clock itself and reports the received word with a one-cycle done pulse. The chip-select line changes only on the explicit select and release commands.

The configuration arrives as a packed mode byte. Bit 0 is clock phase and bit 1 is clock polarity, so SPI mode 0 has neither bit, mode 1 has phase only, mode 2 has polarity only and mode 3 has both. Bit 2 makes the select line active high. Bit 3 sends the least significant bit first. Bit 4 moves the engine onto a single shared data pin. Bit 5 loops the serial output straight back into the receiver. Bits 6 and 7 are ignored. Words are right-justified on the parallel side. A length of zero means 8 bits.

Top module: `spi_shift_engine`

## Requirements
- R1: Phase (bit 0), polarity (bit 1), LSB-first (bit 3), shared line (bit 4), loopback (bit 5) and the divider are captured only when a select command is accepted. Changing `mode_i` or `div_i` while selected has no effect on `sck_o` or on the transfer until the next select command.
- R2: `sck_o` idles at the captured polarity. During a word it toggles once every `div+1` clock cycles, starting `div+1` cycles after the start is accepted, and it makes exactly 2n edges for an n-bit word.
- R3: With phase 0, the first bit is on `mosi_o` from the cycle after start, bits are sampled on the odd-numbered edges (1st, 3rd, ...) and `mosi_o` advances on the even-numbered edges (2nd, 4th, ...) except the last. With phase 1, `mosi_o` advances on the odd-numbered edges and bits are sampled on the even-numbered edges.
- R4: Bits go out and come in most significant bit first unless bit 3 was captured set, which makes the order least significant bit first. The received word is always assembled in the same bit order it was sent.
- R5: The effective length n is `len_i` at start. A value of 0 gives 8, and values above `MAX_W` are treated as `MAX_W`.
- R6: When `tx_valid_i` is low at start, the engine sends all zeros and still captures n received bits.
- R7: Transmit bits at or above n are ignored. `rx_data_o` holds the received word right-justified, with bits at or above n equal to zero.
- R8: `cs_o` equals the select state when `mode_i[2]` is 1 and its inverse when it is 0, so the default is active low. A polarity change shows on `cs_o` without waiting for a clock edge.
- R9: Select, release and start are acted on only while idle, in that priority. A start is ignored unless the device is selected, and a release during a word is ignored.
- R10: With loopback captured, each sampled bit is the bit the engine is driving. `miso_i` and `sio_i` are ignored, so `rx_data_o` equals the transmitted word masked to n bits.
- R11: With the shared-line mode captured, bits are sampled from `sio_i`, and `mosi_oe_o` is low in the cycle after `dir_rx_i` is high. In all other cases `mosi_oe_o` is high one cycle after.
- R12: `done_o` pulses for one cycle, in the cycle that follows the final clock edge. In that same cycle `busy_o` drops and `rx_data_o` takes the new word. `mosi_o` returns to 0 at that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 8 | Packed mode byte |
| cs_assert_i | input | 1 | Select command; captures mode and divider |
| cs_deassert_i | input | 1 | Release command |
| div_i | input | DIV_W | Half-period of the serial clock minus one, in clock cycles |
| len_i | input | LEN_W | Word length, 0 meaning 8 |
| start_i | input | 1 | Start one word |
| tx_valid_i | input | 1 | Transmit data present; zeros are sent when low |
| tx_data_i | input | MAX_W | Right-justified transmit word |
| dir_rx_i | input | 1 | Shared-line direction, 1 = sample |
| miso_i | input | 1 | Serial data from the device |
| sio_i | input | 1 | Pad input of the shared data line |
| sck_o | output | 1 | Serial clock |
| cs_o | output | 1 | Chip select |
| mosi_o | output | 1 | Serial data to the device |
| mosi_oe_o | output | 1 | Output enable of the data pin |
| busy_o | output | 1 | Word in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_data_o | output | MAX_W | Right-justified received word |

## Verification
The four clock modes are each run with a different divider against an external data stream that keeps changing. This separates a wrong sampling edge, a wrong edge count and wrong clock spacing. The bit order is probed with asymmetric words, which shows a reversed or misaligned assembly. Loopback words of 8, 12, 20 and an over-long length, with junk in the upper transmit bits and with transmit data withheld, show whether masking, the zero-length default and the internal return path are correct. Mode changes while selected, a release during a word, a start while unselected and the shared-line direction each show whether the control settings are captured and applied at the right time.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  // Configuration fields; the bit positions match the packed mode byte.
  typedef struct packed {
    logic loop;
    logic three;
    logic lsb;
    logic cs_hi;
    logic cpol;
    logic cpha;
  } mode_t;

  // Effective word length: zero selects a byte, oversize clamps.
  function automatic int eff_len(int len, int maxw);
    if (len == 0) return 8;
    if (len > maxw) return maxw;
    return len;
  endfunction

endpackage

// File: rtl/spi_eng_clkgen.sv
module spi_eng_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
  parameter int MAX_W = 32,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             first_drive,
  input  logic [MAX_W-1:0] word,
  input  logic [LEN_W-1:0] nbits,
  input  logic             lsb,
  input  logic             drive,
  input  logic             sample,
  input  logic             sin,
  input  logic             finish,
  output logic             dout,
  output logic [MAX_W-1:0] rx_word
);

  logic [MAX_W-1:0] tx_q, rx_q, rx_word_q;
  logic [MAX_W-1:0] mask, aligned, tx_src, tx_shf, rx_nxt;
  logic [LEN_W-1:0] n_q;
  logic             dout_q, drv, bit_out;

  always_comb begin
    mask    = {MAX_W{1'b1}} >> (MAX_W - int'(nbits));
    aligned = lsb ? (word & mask) : ((word & mask) << (MAX_W - int'(nbits)));
    tx_src  = load ? aligned : tx_q;
    tx_shf  = lsb ? (tx_src >> 1) : (tx_src << 1);
    drv     = load ? first_drive : drive;
    bit_out = lsb ? tx_src[0] : tx_src[MAX_W-1];
    if (sample) rx_nxt = lsb ? {sin, rx_q[MAX_W-1:1]} : {rx_q[MAX_W-2:0], sin};
    else        rx_nxt = rx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q      <= '0;
      rx_q      <= '0;
      rx_word_q <= '0;
      n_q       <= '0;
      dout_q    <= 1'b0;
    end else begin
      if (load) begin
        n_q  <= nbits;
        rx_q <= '0;
      end else begin
        rx_q <= rx_nxt;
      end
      tx_q <= drv ? tx_shf : tx_src;
      if (finish)   dout_q <= 1'b0;
      else if (drv) dout_q <= bit_out;
      if (finish)
        rx_word_q <= lsb ? (rx_nxt >> (MAX_W - int'(n_q))) : rx_nxt;
    end
  end

  assign dout    = dout_q;
  assign rx_word = rx_word_q;

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter  int MAX_W = 32,
  parameter  int DIV_W = 8,
  localparam int LEN_W = $clog2(MAX_W + 1),
  localparam int EC_W  = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       mode_i,
  input  logic             cs_assert_i,
  input  logic             cs_deassert_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             start_i,
  input  logic             tx_valid_i,
  input  logic [MAX_W-1:0] tx_data_i,
  input  logic             dir_rx_i,
  input  logic             miso_i,
  input  logic             sio_i,
  output logic             sck_o,
  output logic             cs_o,
  output logic             mosi_o,
  output logic             mosi_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [MAX_W-1:0] rx_data_o
);

  mode_t            mode_in, cfg_q;
  logic             unused_mode_hi;
  logic [DIV_W-1:0] div_q;
  logic             sel_q, busy_q, done_q, sck_q, oe_q;
  logic [EC_W-1:0]  ecnt_q, last_idx;
  logic [LEN_W-1:0] nb_q, nb_d;
  logic             do_assert, do_release, do_start;
  logic             tick, odd, edge_last, smp, drv, fin, sin;
  logic [MAX_W-1:0] tx_word;

  assign mode_in        = mode_t'(mode_i[5:0]);
  assign unused_mode_hi = ^mode_i[7:6];

  // Commands are taken only between words; select wins over release over start.
  assign do_assert  = !busy_q && cs_assert_i;
  assign do_release = !busy_q && !cs_assert_i && cs_deassert_i;
  assign do_start   = !busy_q && !cs_assert_i && !cs_deassert_i && start_i && sel_q;

  assign nb_d    = LEN_W'(eff_len(int'(len_i), MAX_W));
  assign tx_word = tx_valid_i ? tx_data_i : '0;

  spi_eng_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_q),
    .div  (div_q),
    .tick (tick)
  );

  // Edge bookkeeping: edge index counts from zero, last index is 2n-1.
  assign last_idx  = {nb_q, 1'b0} - EC_W'(1);
  assign odd       = ecnt_q[0];
  assign edge_last = (ecnt_q == last_idx);
  assign smp       = tick && (cfg_q.cpha ? odd : !odd);
  assign drv       = tick && (cfg_q.cpha ? !odd : (odd && !edge_last));
  assign fin       = tick && edge_last;

  // Receive source: internal return, shared pad, or dedicated input.
  assign sin = cfg_q.loop ? mosi_o : (cfg_q.three ? sio_i : miso_i);

  spi_eng_shifter #(.MAX_W(MAX_W), .LEN_W(LEN_W)) shifter_i (
    .clk         (clk),
    .rst         (rst),
    .load        (do_start),
    .first_drive (!cfg_q.cpha),
    .word        (tx_word),
    .nbits       (nb_d),
    .lsb         (cfg_q.lsb),
    .drive       (drv),
    .sample      (smp),
    .sin         (sin),
    .finish      (fin),
    .dout        (mosi_o),
    .rx_word     (rx_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      div_q  <= '0;
      sel_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      oe_q   <= 1'b1;
      ecnt_q <= '0;
      nb_q   <= '0;
    end else begin
      done_q <= fin;
      oe_q   <= !(cfg_q.three && dir_rx_i);
      if (do_assert) begin
        sel_q <= 1'b1;
        cfg_q <= mode_in;
        div_q <= div_i;
        sck_q <= mode_in.cpol;
      end
      if (do_release) sel_q <= 1'b0;
      if (do_start) begin
        busy_q <= 1'b1;
        ecnt_q <= '0;
        nb_q   <= nb_d;
      end
      if (tick) begin
        sck_q  <= !sck_q;
        ecnt_q <= ecnt_q + 1'b1;
        if (edge_last) busy_q <= 1'b0;
      end
    end
  end

  // Select polarity follows the live mode byte.
  assign cs_o      = mode_in.cs_hi ? sel_q : !sel_q;
  assign sck_o     = sck_q;
  assign mosi_oe_o = oe_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;

endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk (
  input logic clk,
  input logic rst,
  input logic cs_hi,
  input logic cs_assert,
  input logic start,
  input logic dir_rx,
  input logic sck,
  input logic cs,
  input logic oe,
  input logic busy,
  input logic done
);

  // R8
  cs_active_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cs == cs_hi));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R11
  oe_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !dir_rx |=> oe);

  // R9
  start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && !$past(cs_assert)) |-> $stable(sck));

endmodule

bind spi_shift_engine spi_eng_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .cs_hi     (mode_i[2]),
  .cs_assert (cs_assert_i),
  .start     (start_i),
  .dir_rx    (dir_rx_i),
  .sck       (sck_o),
  .cs        (cs_o),
  .oe        (mosi_oe_o),
  .busy      (busy_o),
  .done      (done_o)
);

// File: tb/spi_shift_engine_tb_top.sv
`timescale 1ns/1ps
module spi_shift_engine_tb_top;

  localparam int MAX_W = 32;
  localparam int DIV_W = 8;
  localparam int LEN_W = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [7:0]       mode = '0;
  logic             cs_a = 1'b0, cs_d = 1'b0, start = 1'b0, txv = 1'b0, dir = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic [LEN_W-1:0] len = '0;
  logic [MAX_W-1:0] txd = '0;
  logic             miso = 1'b0, sio = 1'b0;
  logic             sck_o, cs_o, mosi_o, mosi_oe_o, busy_o, done_o;
  logic [MAX_W-1:0] rx_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_shift_engine #(.MAX_W(MAX_W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode), .cs_assert_i(cs_a), .cs_deassert_i(cs_d),
    .div_i(div), .len_i(len), .start_i(start), .tx_valid_i(txv), .tx_data_i(txd),
    .dir_rx_i(dir), .miso_i(miso), .sio_i(sio), .sck_o(sck_o), .cs_o(cs_o),
    .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .busy_o(busy_o), .done_o(done_o),
    .rx_data_o(rx_data_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_sel, m_busy, m_t, m_n, m_div, m_sidx, m_e, m_k, m_d;
  bit m_cpha, m_cpol, m_lsb, m_three, m_loop;
  bit m_sck, m_mosi, m_oe, m_done, m_oe_n;
  logic [31:0] m_word, m_rx;
  bit m_bits [0:63];

  function automatic int ref_len(int l);
    if (l == 0) return 8;
    if (l > MAX_W) return MAX_W;
    return l;
  endfunction

  function automatic bit bit_at(int j);
    return m_lsb ? m_word[j] : m_word[m_n-1-j];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sel = 0; m_busy = 0; m_t = 0; m_n = 8; m_div = 0; m_sidx = 0;
      {m_cpha, m_cpol, m_lsb, m_three, m_loop} = '0;
      m_sck = 0; m_mosi = 0; m_oe = 1; m_done = 0; m_word = 0; m_rx = 0;
    end else begin
      m_oe_n = !(m_three && dir);
      m_done = 0;
      if (m_busy != 0) begin
        m_t++;
        if (m_t % (m_div + 1) == 0) begin
          m_e = m_t / (m_div + 1);
          m_k = m_e - 1;
          m_sck = !m_sck;
          if (((m_k % 2) == 1) == m_cpha) begin
            m_bits[m_sidx] = m_loop ? m_mosi : (m_three ? sio : miso);
            m_sidx++;
          end
          if (m_e == 2 * m_n) begin
            m_busy = 0; m_done = 1; m_mosi = 0; m_rx = 0;
            for (int j = 0; j < m_n; j++) begin
              if (m_lsb) m_rx[j] = m_bits[j];
              else       m_rx[m_n-1-j] = m_bits[j];
            end
          end else begin
            if (m_cpha) m_d = (m_e + 1) / 2;
            else        m_d = 1 + (((m_e / 2) < (m_n - 1)) ? (m_e / 2) : (m_n - 1));
            if (m_d > 0) m_mosi = bit_at(m_d - 1);
          end
        end
      end else if (cs_a) begin
        m_sel = 1; m_div = int'(div);
        m_cpha = mode[0]; m_cpol = mode[1]; m_lsb = mode[3]; m_three = mode[4]; m_loop = mode[5];
        m_sck = m_cpol;
      end else if (cs_d) begin
        m_sel = 0;
      end else if (start && m_sel != 0) begin
        m_busy = 1; m_t = 0; m_sidx = 0;
        m_n = ref_len(int'(len));
        m_word = txv ? txd : 32'h0;
        if (!m_cpha) m_mosi = bit_at(0);
      end
      m_oe = m_oe_n;
    end
  end

  // Compare every cycle, away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        chk("R2 sck", sck_o, m_sck);
        chk("R3 R4 mosi", mosi_o, m_mosi);
        chk("R8 cs", cs_o, mode[2] ? (m_sel != 0) : (m_sel == 0));
        chk("R11 oe", mosi_oe_o, m_oe);
        chk("R12 done", done_o, m_done);
        chk("R12 busy", busy_o, m_busy != 0);
        chk("R7 rx", rx_data_o, m_rx);
      end
    end
  end

  // Device-side data streams that change every cycle.
  initial begin
    logic [15:0] lf = 16'hACE1;
    forever begin
      @(negedge clk); #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      miso = lf[0];
      sio  = lf[7];
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_neg();
    @(negedge clk); #1;
  endtask

  task automatic select(logic [7:0] mb, int d);
    wait_neg(); mode = mb; div = DIV_W'(d); cs_a = 1;
    wait_neg(); cs_a = 0;
  endtask

  task automatic release_cs();
    wait_neg(); cs_d = 1;
    wait_neg(); cs_d = 0;
  endtask

  task automatic xfer(logic [31:0] w, bit v, int l);
    wait_neg(); txd = w; txv = v; len = LEN_W'(l); start = 1;
    wait_neg(); start = 0; txv = 0; txd = 32'hFFFF_FFFF;
    do @(negedge clk); while (!done_o);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    wait_neg(); rst = 0;
    @(negedge clk);
    chk("R8 reset cs", cs_o, 1'b1);
    chk("R12 reset busy", busy_o, 1'b0);
    chk("R7 reset rx", rx_data_o, 32'h0);
    chk("R2 reset sck", sck_o, 1'b0);

    // R9: start while unselected is ignored
    wait_neg(); start = 1; len = 8;
    wait_neg(); start = 0;
    wait_neg();
    chk("R9 start unselected", busy_o, 1'b0);

    // R3: four clock modes with different dividers
    for (int md = 0; md < 4; md++) begin
      select(8'(md), md);
      xfer(32'hA5 ^ 32'(md * 17), 1, 8);
      chk("R3 rx mode", rx_data_o, m_rx);
      release_cs();
    end

    // R4: LSB-first, 12-bit, external data
    select(8'h08, 1);
    xfer(32'h0000_0B41, 1, 12);
    chk("R4 lsb rx", rx_data_o, m_rx);
    release_cs();

    // R6: no transmit data, external receive
    select(8'h01, 0);
    xfer(32'h0, 0, 16);
    chk("R6 zero tx rx", rx_data_o, m_rx);
    release_cs();

    // Loopback cases
    select(8'h20, 0);
    xfer(32'h0000_01A5, 1, 0);
    chk("R5 R10 len0 loop", rx_data_o, 32'h0000_00A5);
    xfer(32'hFFFF_F123, 1, 12);
    chk("R7 R10 mask loop", rx_data_o, 32'h0000_0123);
    xfer(32'hDEAD_BEEF, 1, 40);
    chk("R5 clamp loop", rx_data_o, 32'hDEAD_BEEF);
    xfer(32'h1234_5678, 0, 8);
    chk("R6 R10 zero loop", rx_data_o, 32'h0);
    release_cs();
    select(8'h2B, 2);
    xfer(32'hFFF5_A5A5, 1, 20);
    chk("R4 R10 lsb loop", rx_data_o, 32'h0005_A5A5);
    release_cs();

    // R1: mode change while selected waits for next select
    select(8'h00, 1);
    wait_neg(); mode = 8'h03;
    wait_neg();
    chk("R1 sck held", sck_o, 1'b0);
    xfer(32'h0000_003C, 1, 6);
    chk("R1 rx old mode", rx_data_o, m_rx);
    release_cs();
    select(8'h03, 1);
    chk("R1 sck new", sck_o, 1'b1);
    release_cs();

    // R8: select polarity applies at once
    select(8'h00, 0);
    chk("R8 active low", cs_o, 1'b0);
    wait_neg(); mode = 8'h04;
    @(negedge clk);
    chk("R8 active high", cs_o, 1'b1);
    wait_neg(); mode = 8'h00;

    // R9: release during a word is ignored
    select(8'h00, 3);
    wait_neg(); txd = 32'h5A; txv = 1; len = 8; start = 1;
    wait_neg(); start = 0;
    repeat (5) wait_neg();
    cs_d = 1;
    wait_neg(); cs_d = 0;
    chk("R9 release ignored cs", cs_o, 1'b0);
    chk("R9 busy kept", busy_o, 1'b1);
    do @(negedge clk); while (!done_o);
    release_cs();
    @(negedge clk);
    chk("R9 released", cs_o, 1'b1);

    // R11: shared data line
    select(8'h10, 1);
    wait_neg(); dir = 1;
    @(negedge clk); @(negedge clk);
    chk("R11 oe off", mosi_oe_o, 1'b0);
    xfer(32'h0, 0, 10);
    chk("R11 sio rx", rx_data_o, m_rx);
    wait_neg(); dir = 0;
    @(negedge clk); @(negedge clk);
    chk("R11 oe on", mosi_oe_o, 1'b1);
    release_cs();

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule